// File: doc/BRIEF.md
# Line-Controlled UART Transmitter

This block turns bytes written by a host into asynchronous serial frames on one output line. The host talks to it through a small write/read register port with three addresses: a transmit data address, a spare address, and an 8-bit line control register. The line control register sets the character length and the number of stop bits. It also sets whether a parity bit is sent and which parity rule applies: odd, even, constant mark or constant space. One bit holds the line low for a break. Another bit turns the first two addresses into the low and high bytes of a 16-bit baud divisor.

Each frame is timed by an internal tick at sixteen times the baud rate, so every bit lasts 16 × divisor clock cycles. A busy flag tells the host when the next byte may be written. The settings that shape a frame are sampled when the byte is accepted. A break acts on the line at once, whatever the frame is doing.

Top module: `uart_line_tx`

## Requirements
- R1: After reset, tx is high, busy is low, the line control register reads 0x00 and the divisor is 0. That means 5 data bits, one stop bit, no parity and an effective divisor of 1.
- R2: Address 2 reads and writes the line control register. When its bit 7 is set, address 0 reads and writes divisor bits 7:0 and address 1 reads and writes divisor bits 15:8. When bit 7 is clear, a write to address 0 sends a byte, address 0 reads 0, and a write to address 1 has no effect.
- R3: A frame is one low start bit, then the data bits LSB first, then the stop bits, which are high. The line idles high. Line control bits 1:0 give the data length: 00, 01, 10 and 11 mean 5, 6, 7 and 8 bits.
- R4: Line control bit 2 at 0 gives one stop bit. At 1 it gives two stop bits.
- R5: Line control bit 3 at 0 sends no parity bit. At 1 it sends a parity bit right after the data bits. When bits 5 and 4 are both 0, the parity is odd: data ones plus the parity bit make an odd count.
- R6: With bit 3 set, bit 5 clear and bit 4 set, the parity is even.
- R7: With bits 3 and 5 set, the parity bit is a constant. It is 1 when bit 4 is 0 and 0 when bit 4 is 1.
- R8: Each bit lasts 16 × D clock cycles. D is the divisor captured when the byte is accepted, with 0 treated as 1. A divisor written during a frame changes only later frames.
- R9: A data write is accepted only while busy is low. busy is high from the cycle after acceptance until the last stop bit ends, so the frame takes 16 × D × (frame bits) cycles. A data write while busy is dropped and sends nothing.
- R10: While line control bit 6 is set, tx is low from the cycle after the write. When the bit clears, tx returns to what the frame would show. The frame keeps its timing under a break.
- R11: Line control changes other than bit 6 that are made during a frame apply only to the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tx | output | 1 | Serial output line |
| busy | output | 1 | High while a frame is being sent |

## Verification
The bench makes a break request arrive while the frame shifter keeps advancing underneath it. It does this by writing the break bit partway into a data frame and clearing it two bit periods later. The bench then expects exactly the two data bits whose midpoints fall inside the break to read low. The bits on either side must keep their normal values, and busy must still fall at the cycle the undisturbed frame length predicts. A second case writes the line control register and the divisor while a frame is in flight. That frame must keep its old shape and timing, and the following frame must take the new ones.

// File: rtl/uart_line_tx.sv
module uart_line_tx #(
  parameter int DIV_W    = 16,
  parameter int MAX_DATA = 8,
  parameter int OVS      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       tx,
  output logic       busy
);
  localparam int FRAME_W = MAX_DATA + 4;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int SUB_W   = $clog2(OVS);
  localparam int HI_W    = DIV_W - 8;

  logic [7:0]         lcr;
  logic [DIV_W-1:0]   div_reg, div_act, bcnt;
  logic [SUB_W-1:0]   sub;
  logic [IDX_W-1:0]   bits_left;
  logic [FRAME_W-1:0] shreg, frame_nxt;
  logic [IDX_W-1:0]   wlen, frame_len;
  logic               busy_q, par_bit, data_ones;

  wire dlab    = lcr[7];
  wire brk     = lcr[6];
  wire wr_data = reg_wr && reg_addr == 2'd0 && !dlab;
  wire accept  = wr_data && !busy_q;
  wire tick    = busy_q && (bcnt == div_act - 1'b1);
  wire bit_end = tick && (sub == SUB_W'(OVS - 1));
  wire [DIV_W-1:0] div_eff = (div_reg == '0) ? DIV_W'(1) : div_reg;

  assign tx   = brk ? 1'b0 : shreg[0];
  assign busy = busy_q;

  assign wlen      = IDX_W'(5) + IDX_W'(lcr[1:0]);
  assign frame_len = wlen + IDX_W'(2) + IDX_W'(lcr[3]) + IDX_W'(lcr[2]);

  always_comb begin
    data_ones = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < int'(wlen)) data_ones = data_ones ^ reg_wdata[i];
    if (lcr[5]) par_bit = ~lcr[4];
    else        par_bit = lcr[4] ? data_ones : ~data_ones;
    frame_nxt    = '1;
    frame_nxt[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < int'(wlen)) frame_nxt[i+1] = reg_wdata[i];
    if (lcr[3]) frame_nxt[wlen + IDX_W'(1)] = par_bit;
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = dlab ? div_reg[7:0] : 8'h00;
      2'd1:    reg_rdata = dlab ? 8'(div_reg[DIV_W-1:8]) : 8'h00;
      2'd2:    reg_rdata = lcr;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr     <= '0;
      div_reg <= '0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd2) lcr <= reg_wdata;
      if (dlab && reg_addr == 2'd0) div_reg[7:0] <= reg_wdata;
      if (dlab && reg_addr == 2'd1) div_reg[DIV_W-1:8] <= reg_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '1;
      bits_left <= '0;
      busy_q    <= 1'b0;
      bcnt      <= '0;
      sub       <= '0;
      div_act   <= DIV_W'(1);
    end else if (accept) begin
      shreg     <= frame_nxt;
      bits_left <= frame_len;
      busy_q    <= 1'b1;
      bcnt      <= '0;
      sub       <= '0;
      div_act   <= div_eff;
    end else if (busy_q) begin
      if (tick) begin
        bcnt <= '0;
        sub  <= bit_end ? '0 : sub + 1'b1;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
      if (bit_end) begin
        shreg     <= {1'b1, shreg[FRAME_W-1:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == IDX_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (brk || !tx));
  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> tx);
  assert_busy_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_drop_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_data && !bit_end) |=> ($stable(bits_left) && $stable(shreg)));
  assert_tick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sub));
  assert_len_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bits_left != '0 && bits_left <= IDX_W'(FRAME_W)));
endmodule

// File: tb/uart_line_tx_tb_top.sv
module uart_line_tx_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tx, busy;

  int checks = 0;
  int failures = 0;
  logic [7:0]  m_lcr = 8'h00;
  logic [15:0] m_div = 16'h0000;

  typedef struct {
    logic [11:0] bits;
    logic [11:0] brk_mask;
    int          n;
    int          d;
    string       tag;
  } frame_t;
  frame_t sb[$];

  uart_line_tx dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx(tx), .busy(busy)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 2'd2) m_lcr = d;
    else if (m_lcr[7] && a == 2'd0) m_div[7:0] = d;
    else if (m_lcr[7] && a == 2'd1) m_div[15:8] = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_div(input logic [15:0] v);
    logic [7:0] keep;
    keep = m_lcr;
    write_reg(2'd2, keep | 8'h80);
    write_reg(2'd0, v[7:0]);
    write_reg(2'd1, v[15:8]);
    write_reg(2'd2, keep);
  endtask

  function automatic frame_t make_frame(input logic [7:0] data, input logic [7:0] lc,
                                        input logic [15:0] dv, input string tag);
    frame_t f;
    int wl, ones, p;
    wl = 5 + int'(lc[1:0]);
    ones = 0;
    f.bits = '1;
    f.bits[0] = 1'b0;
    f.n = 1;
    for (int i = 0; i < wl; i++) begin
      f.bits[f.n] = data[i];
      ones += int'(data[i]);
      f.n++;
    end
    if (lc[3]) begin
      if (lc[5]) p = lc[4] ? 0 : 1;
      else if (lc[4]) p = ones % 2;
      else p = (ones % 2 == 0) ? 1 : 0;
      f.bits[f.n] = p[0];
      f.n++;
    end
    f.n += lc[2] ? 2 : 1;
    f.brk_mask = '0;
    f.d = (dv == 16'h0) ? 1 : int'(dv);
    f.tag = tag;
    return f;
  endfunction

  task automatic send_byte(input logic [7:0] data, input string tag,
                           input logic [11:0] bmask = '0);
    frame_t f;
    wait_idle();
    f = make_frame(data, m_lcr, m_div, tag);
    f.brk_mask = bmask;
    sb.push_back(f);
    write_reg(2'd0, data);
  endtask

  initial begin : monitor
    frame_t f;
    forever begin
      do @(negedge clk); while (!busy);
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected frame", 1, 0);
      end else begin
        f = sb.pop_front();
        repeat (8 * f.d) @(negedge clk);
        for (int k = 0; k < f.n; k++) begin
          logic e;
          e = f.brk_mask[k] ? 1'b0 : f.bits[k];
          check(tx === e, $sformatf("%s bit%0d", f.tag, k), int'(tx), int'(e));
          if (k < f.n - 1) repeat (16 * f.d) @(negedge clk);
        end
        repeat (8 * f.d - 1) @(negedge clk);
        check(busy === 1'b1, {f.tag, " R9 busy before end"}, int'(busy), 1);
        @(negedge clk);
        check(busy === 1'b0, {f.tag, " R9 busy after end"}, int'(busy), 0);
        check(tx === 1'b1, {f.tag, " R3 idle high"}, int'(tx), 1);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    check(tx === 1'b1, "R1 tx reset", int'(tx), 1);
    check(busy === 1'b0, "R1 busy reset", int'(busy), 0);
    rst_n = 1'b1;
    read_reg(2'd2, rv);
    check(rv == 8'h00, "R1 lcr reset", int'(rv), 0);

    send_byte(8'h15, "R1 R3 default 5N1 div0");

    wait_idle();
    write_reg(2'd2, 8'h80);
    read_reg(2'd0, rv);
    check(rv == 8'h00, "R1 div low reset", int'(rv), 0);
    write_reg(2'd0, 8'h02);
    write_reg(2'd1, 8'h01);
    read_reg(2'd0, rv);
    check(rv == 8'h02, "R2 div low readback", int'(rv), 2);
    read_reg(2'd1, rv);
    check(rv == 8'h01, "R2 div high readback", int'(rv), 1);
    check(busy === 1'b0, "R2 no frame from divisor write", int'(busy), 0);
    write_reg(2'd2, 8'h00);
    read_reg(2'd0, rv);
    check(rv == 8'h00, "R2 data addr reads 0", int'(rv), 0);
    write_reg(2'd1, 8'h77);
    check(busy === 1'b0, "R2 addr1 write no frame", int'(busy), 0);
    write_reg(2'd2, 8'h80);
    read_reg(2'd1, rv);
    check(rv == 8'h01, "R2 addr1 ignored without dlab", int'(rv), 1);
    write_reg(2'd2, 8'h00);
    send_byte(8'h0A, "R8 divisor 258");

    wait_idle();
    set_div(16'd1);
    write_reg(2'd2, 8'h01); send_byte(8'h2D, "R3 6 bits");
    wait_idle(); write_reg(2'd2, 8'h02); send_byte(8'h5B, "R3 7 bits");
    wait_idle(); write_reg(2'd2, 8'h03); send_byte(8'hA6, "R3 8 bits");
    wait_idle(); write_reg(2'd2, 8'h07); send_byte(8'hC3, "R4 two stops");
    wait_idle(); write_reg(2'd2, 8'h0B); send_byte(8'h81, "R5 odd even-ones");
    send_byte(8'h07, "R5 odd odd-ones");
    wait_idle(); write_reg(2'd2, 8'h1B); send_byte(8'h81, "R6 even even-ones");
    send_byte(8'h07, "R6 even odd-ones");
    wait_idle(); write_reg(2'd2, 8'h28); send_byte(8'h1F, "R7 mark");
    wait_idle(); write_reg(2'd2, 8'h38); send_byte(8'h1F, "R7 space");
    wait_idle(); write_reg(2'd2, 8'h3F); send_byte(8'h00, "R7 R4 space 8b two stops");

    wait_idle(); write_reg(2'd2, 8'h03);
    send_byte(8'h3C, "R9 drop write");
    repeat (20) @(negedge clk);
    write_reg(2'd0, 8'hFF);
    @(negedge clk);
    wait_idle();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i % 10 == 0) begin
        check(busy === 1'b0, "R9 dropped write stays idle", int'(busy), 0);
        check(tx === 1'b1, "R9 dropped write no line activity", int'(tx), 1);
      end
    end

    send_byte(8'hA5, "R11 old settings kept");
    repeat (30) @(negedge clk);
    write_reg(2'd2, 8'h18);
    set_div(16'd3);
    send_byte(8'h1F, "R11 R8 new settings");

    wait_idle();
    write_reg(2'd2, 8'h40);
    @(negedge clk);
    check(tx === 1'b0, "R10 break idle low", int'(tx), 0);
    repeat (20) @(negedge clk);
    check(tx === 1'b0, "R10 break held", int'(tx), 0);
    check(busy === 1'b0, "R10 break no busy", int'(busy), 0);
    write_reg(2'd2, 8'h00);
    check(tx === 1'b1, "R10 break released", int'(tx), 1);

    write_reg(2'd2, 8'h03);
    set_div(16'd2);
    send_byte(8'h6B, "R10 break mid frame", 12'b0000_0000_1100);
    repeat (58) @(negedge clk);
    write_reg(2'd2, 8'h43);
    repeat (60) @(negedge clk);
    write_reg(2'd2, 8'h03);

    wait_idle();
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R9 all frames sent", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule